// File: doc/BRIEF.md
# Float32 Reciprocal Square Root Unit

This block takes one IEEE-754 single-precision operand and returns 1/sqrt(x) as a single-precision value, together with an invalid-operation flag and a divide-by-zero flag that belong to that result. Operands arrive on a valid/ready input port and results leave on a valid/ready output port. Exactly one operation is in flight at any time.

Ordinary positive operands go through an iterative core. The unbiased exponent is halved; when it is odd, the significand is doubled first, so the halving is exact. The core then finds the root significand one bit per cycle: it keeps the running value y, y*m and y*y*m, and tests each candidate bit against a fixed limit. This gives a truncated root with FRAC_W fractional bits and an exactness indication. Rounding to nearest-even then packs that root. Operands that are special are classified at the input. The classifier flushes subnormals to a zero of the same sign, then picks the output bits and flags. These operands still pass through the same fixed number of cycles, so every result takes the same time.

Top module: `rsq_unit`

## Requirements
- R1: After an operand is accepted on a rising clock edge, out_valid rises exactly FRAC_W+1 rising edges later, whatever the operand class.
- R2: in_ready is high only when the unit is empty. From the accepting edge until the result is taken, in_ready stays low and in_valid has no effect. After the edge on which out_valid and out_ready are both high, out_valid is low and in_ready is high.
- R3: While out_valid is high and out_ready is low, out_valid, out_data, out_invalid and out_divzero all hold their values.
- R4: For a positive normal operand, out_data is a positive normal float32 within 2^-23 relative error of 1/sqrt(x). It is the round-to-nearest-even value of a root truncated to FRAC_W fractional bits, and FRAC_W is at least 25.
- R5: An operand that is exactly 2^(-2n) returns exactly 2^n with no flags; for example 0x3E800000 gives 0x40000000 and 0x00800000 gives 0x5F000000.
- R6: A NaN operand (exponent field 0xFF, fraction nonzero) returns its own bits with bit 22 set. out_invalid is high only when bit 22 of the operand was clear (signaling).
- R7: A negative operand that is neither zero nor subnormal nor NaN, which includes 0xFF800000, returns 0xFFC00000 with out_invalid high.
- R8: -0 (0x80000000) or a negative subnormal returns 0xFF800000 with out_divzero high.
- R9: +0 or a positive subnormal returns 0x7F800000 with out_divzero high.
- R10: +infinity (0x7F800000) returns 0x00000000 with both flags low.
- R11: Both flags are low for a positive normal operand, and the two flags are never high together.
- R12: While reset is held and on the first cycle after it, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in sync with clk |
| in_valid | input | 1 | Operand present on in_data |
| in_ready | output | 1 | Unit is empty and can take an operand |
| in_data | input | 32 | Operand, float32 bit pattern |
| out_valid | output | 1 | Result present on out_data and flags |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result, float32 bit pattern |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_divzero | output | 1 | Divide-by-zero flag for this result |

## Verification
A wrong bit decision in the root core cannot be seen until the result comes out, FRAC_W+1 cycles after acceptance. It then shows as a relative error above 2^-23, or as an inexact value where 2^(-2n) operands need an exact power of two. A fault in the control counter or state shows up sooner: the behavioural handshake model compares in_ready and out_valid on every clock and catches a result that comes early or late. A misclassified special operand appears as a wrong bit pattern or wrong flag in the same result, and the bench checks those bit-exactly.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int FP_W   = 32;
  localparam int MAN_W  = 23;
  localparam int EXP_W  = 8;
  // scaled significand: m in [1,4) held as m * 2^MAN_W
  localparam int SIG_W  = MAN_W + 2;

  localparam logic [FP_W-1:0] QNAN_INDEF = 32'hFFC0_0000;
  localparam logic [FP_W-1:0] POS_INF    = 32'h7F80_0000;
  localparam logic [FP_W-1:0] NEG_INF    = 32'hFF80_0000;
  localparam logic [FP_W-1:0] QUIET_BIT  = 32'h0040_0000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } rsq_state_e;

  // decoded operand: bypass value for specials, exponent base for normals
  typedef struct packed {
    logic             special;
    logic [FP_W-1:0]  spec_val;
    logic             spec_inv;
    logic             spec_dz;
    logic [EXP_W-1:0] exp_hi;
  } rsq_op_t;

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
  import rsq_pkg::*;
(
  input  logic [FP_W-1:0]  x,
  output rsq_op_t          op,
  output logic [SIG_W-1:0] sig
);

  logic [EXP_W-1:0] ef;
  logic [MAN_W-1:0] fr;
  logic             sgn;
  logic             is_nan;
  logic             is_inf;
  logic             is_zero;
  logic             odd_exp;
  logic signed [9:0] e_unb;
  logic signed [9:0] e_even;
  logic signed [9:0] e_half;
  logic signed [9:0] e_res;

  assign sgn     = x[FP_W-1];
  assign ef      = x[FP_W-2 -: EXP_W];
  assign fr      = x[MAN_W-1:0];
  assign is_nan  = (&ef) && (|fr);
  assign is_inf  = (&ef) && !(|fr);
  assign is_zero = (ef == '0);          // subnormals flushed here
  // bias is odd, so an even biased field means an odd true exponent
  assign odd_exp = ~ef[0];

  always_comb begin
    e_unb  = $signed({2'b00, ef}) - 10'sd127;
    e_even = odd_exp ? (e_unb - 10'sd1) : e_unb;
    e_half = e_even >>> 1;
    e_res  = 10'sd127 - e_half;
  end

  always_comb begin
    sig = odd_exp ? {1'b1, fr, 1'b0} : {2'b01, fr};
    op.special  = 1'b1;
    op.spec_val = '0;
    op.spec_inv = 1'b0;
    op.spec_dz  = 1'b0;
    op.exp_hi   = e_res[EXP_W-1:0];
    if (is_nan) begin
      op.spec_val = x | QUIET_BIT;
      op.spec_inv = ~x[MAN_W-1];
    end else if (is_zero) begin
      op.spec_val = sgn ? NEG_INF : POS_INF;
      op.spec_dz  = 1'b1;
    end else if (sgn) begin
      op.spec_val = QNAN_INDEF;
      op.spec_inv = 1'b1;
    end else if (is_inf) begin
      op.spec_val = '0;
    end else begin
      op.special  = 1'b0;
    end
  end

endmodule

// File: rtl/rsq_root_iter.sv
module rsq_root_iter
  import rsq_pkg::*;
#(
  parameter int FRAC_W = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [SIG_W-1:0]          sig_in,
  input  logic                      step,
  input  logic [$clog2(FRAC_W+1)-1:0] bit_idx,
  output logic [FRAC_W:0]           root,
  output logic                      exact
);

  localparam int Y_W = FRAC_W + 1;
  localparam int P_W = Y_W + SIG_W;
  localparam int T_W = 2 * FRAC_W + 28;
  localparam logic [T_W-1:0] T_ONE = 1;
  // (y / 2^FRAC_W)^2 * m <= 1  <=>  y^2 * sig <= 2^(2*FRAC_W + MAN_W)
  localparam logic [T_W-1:0] LIMIT = T_ONE << (2 * FRAC_W + MAN_W);
  localparam logic [Y_W-1:0] Y_ONE = 1;

  logic [SIG_W-1:0] m_q;
  logic [Y_W-1:0]   y_q, y_d;
  logic [P_W-1:0]   p_q, p_d;
  logic [T_W-1:0]   s_q, s_d;
  logic [T_W-1:0]   trial;
  logic             take;
  logic             en;

  always_comb begin
    trial = s_q
          + (T_W'(p_q) << (int'(bit_idx) + 1))
          + (T_W'(m_q) << (2 * int'(bit_idx)));
    take  = (trial <= LIMIT);
  end

  always_comb begin
    y_d = y_q;
    p_d = p_q;
    s_d = s_q;
    if (load) begin
      y_d = '0;
      p_d = '0;
      s_d = '0;
    end else if (take) begin
      y_d = y_q | (Y_ONE << bit_idx);
      p_d = p_q + (P_W'(m_q) << bit_idx);
      s_d = trial;
    end
  end

  assign en = load | step;

  always_ff @(posedge clk) begin
    if (load) begin
      m_q <= sig_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
      p_q <= '0;
      s_q <= '0;
    end else if (en) begin
      y_q <= y_d;
      p_q <= p_d;
      s_q <= s_d;
    end
  end

  assign root  = y_q;
  assign exact = (s_q == LIMIT);

endmodule

// File: rtl/rsq_pack.sv
module rsq_pack
  import rsq_pkg::*;
#(
  parameter int FRAC_W = 30
) (
  input  rsq_op_t          op,
  input  logic [FRAC_W:0]  root,
  input  logic             exact,
  output logic [FP_W-1:0]  res,
  output logic             flag_inv,
  output logic             flag_dz
);

  logic [FRAC_W-1:0] norm;
  logic [EXP_W-1:0]  e_base;
  logic [MAN_W-1:0]  frac_t;
  logic              guard;
  logic              sticky;
  logic              rnd_up;
  logic [MAN_W:0]    frac_r;
  logic [EXP_W-1:0]  e_out;

  always_comb begin
    // root in (0.5, 1]: bit FRAC_W set only for the value 1.0
    if (root[FRAC_W]) begin
      norm   = root[FRAC_W-1:0];
      e_base = op.exp_hi;
    end else begin
      norm   = {root[FRAC_W-2:0], 1'b0};
      e_base = op.exp_hi - 8'd1;
    end
    frac_t = norm[FRAC_W-1 -: MAN_W];
    guard  = norm[FRAC_W-1-MAN_W];
    sticky = (|norm[FRAC_W-2-MAN_W:0]) | ~exact;
    rnd_up = guard & (sticky | frac_t[0]);
    frac_r = {1'b0, frac_t} + {{MAN_W{1'b0}}, rnd_up};
    e_out  = e_base + {{(EXP_W-1){1'b0}}, frac_r[MAN_W]};
  end

  always_comb begin
    if (op.special) begin
      res      = op.spec_val;
      flag_inv = op.spec_inv;
      flag_dz  = op.spec_dz;
    end else begin
      res      = {1'b0, e_out, frac_r[MAN_W-1:0]};
      flag_inv = 1'b0;
      flag_dz  = 1'b0;
    end
  end

endmodule

// File: rtl/rsq_unit.sv
module rsq_unit
  import rsq_pkg::*;
#(
  parameter int FRAC_W = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_invalid,
  output logic        out_divzero
);

  localparam int BIT_W = $clog2(FRAC_W + 1);

  rsq_state_e       state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  rsq_op_t          op_in, op_q;
  logic [SIG_W-1:0] sig_in;
  logic [FRAC_W:0]  root;
  logic             exact;
  logic             accept;
  logic             stepping;

  generate
    if (FRAC_W < MAN_W + 2) begin : g_bad_width
      initial $fatal(1, "FRAC_W must be at least 25");
    end
  endgenerate

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign accept    = in_valid & in_ready;
  assign stepping  = (state_q == ST_BUSY);

  rsq_classify u_classify (
    .x   (in_data),
    .op  (op_in),
    .sig (sig_in)
  );

  rsq_root_iter #(.FRAC_W(FRAC_W)) u_root (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .sig_in  (sig_in),
    .step    (stepping),
    .bit_idx (bit_q),
    .root    (root),
    .exact   (exact)
  );

  rsq_pack #(.FRAC_W(FRAC_W)) u_pack (
    .op       (op_q),
    .root     (root),
    .exact    (exact),
    .res      (out_data),
    .flag_inv (out_invalid),
    .flag_dz  (out_divzero)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_BUSY;
          bit_d   = BIT_W'(FRAC_W);
        end
      end
      ST_BUSY: begin
        if (bit_q == '0) begin
          state_d = ST_DONE;
        end else begin
          bit_d = bit_q - 1'b1;
        end
      end
      ST_DONE: begin
        if (out_ready) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q <= op_in;
    end
  end

endmodule

// File: rtl/rsq_unit_chk.sv
module rsq_unit_chk #(
  parameter int FRAC_W = 30
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_invalid,
  input logic        out_divzero
);

  localparam int LAT   = FRAC_W + 1;
  localparam int CNT_W = $clog2(LAT + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_acc <= '0;
    end else if (in_valid && in_ready) begin
      since_acc <= '0;
    end else if (since_acc != CNT_MAX) begin
      since_acc <= since_acc + 1'b1;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since_acc == CNT_W'(LAT)));

  p_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
      && $stable(out_invalid) && $stable(out_divzero)));

  p_inv_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> ((&out_data[30:23]) && out_data[22]));

  p_dz_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_divzero) |-> (out_data[30:0] == 31'h7F80_0000));

  p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_divzero));

endmodule

bind rsq_unit rsq_unit_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_invalid (out_invalid),
  .out_divzero (out_divzero)
);

// File: tb/rsq_unit_tb.sv
module rsq_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FRAC_W     = 30;
  localparam int LAT        = FRAC_W + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'h0;
  logic        out_ready = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_invalid;
  logic        out_divzero;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [31:0] rs = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsq_unit #(.FRAC_W(FRAC_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_invalid (out_invalid),
    .out_divzero (out_divzero)
  );

  // behavioural handshake model: 0 empty, 1 working, 2 holding result
  int m_state = 0;
  int m_cnt   = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0;
      m_cnt   <= 0;
    end else begin
      case (m_state)
        0: if (in_valid) begin m_state <= 1; m_cnt <= 1; end
        1: if (m_cnt == LAT) m_state <= 2; else m_cnt <= m_cnt + 1;
        default: if (out_ready) m_state <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_tests++;
      if (in_ready !== (m_state == 0) || out_valid !== (m_state == 2)) begin
        n_fail++;
        $display("FAIL R1/R2 cycle model: in_ready=%b out_valid=%b expected %b %b",
                 in_ready, out_valid, m_state == 0, m_state == 2);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic real f2r(input logic [31:0] v);
    int  e;
    real s;
    e = int'(v[30:23]) - 127;
    s = 1.0 + real'(v[22:0]) / 8388608.0;
    for (int i = 0; i < e; i++) s = s * 2.0;
    for (int i = 0; i > e; i--) s = s / 2.0;
    return s;
  endfunction

  task automatic run_op(input logic [31:0] x, input int hold,
                        output logic [31:0] r, output logic fi, output logic fz);
    int lat;
    @(negedge clk);
    check(in_ready === 1'b1, "R2", "ready before issue", {31'h0, in_ready}, 32'h1);
    in_valid = 1'b1;
    in_data  = x;
    @(posedge clk);
    @(negedge clk);
    // keep offering junk while busy: must be ignored (R2)
    in_data = ~x;
    lat = 0;
    while (!out_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    check(lat == LAT, "R1", "latency", lat, LAT);
    r  = out_data;
    fi = out_invalid;
    fz = out_divzero;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_data === r && out_invalid === fi
            && out_divzero === fz, "R3", "held result", out_data, r);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R2", "after pop",
          {30'h0, out_valid, in_ready}, 32'h1);
  endtask

  task automatic check_special(input logic [31:0] x, input logic [31:0] exp,
                               input logic ei, input logic ez, input string req);
    logic [31:0] r;
    logic fi, fz;
    run_op(x, 0, r, fi, fz);
    check(r === exp, req, "special value", r, exp);
    check(fi === ei && fz === ez, req, "special flags",
          {30'h0, fi, fz}, {30'h0, ei, ez});
  endtask

  task automatic check_normal(input logic [31:0] x, input int hold);
    logic [31:0] r;
    logic fi, fz;
    real ref_v, got, err;
    run_op(x, hold, r, fi, fz);
    ref_v = 1.0 / $sqrt(f2r(x));
    check(r[31] == 1'b0 && r[30:23] != 8'h00 && r[30:23] != 8'hFF,
          "R4", "normal class", r, 32'h3F80_0000);
    got = f2r(r);
    err = (got - ref_v) / ref_v;
    if (err < 0.0) err = -err;
    check(err < 1.0 / 8388608.0, "R4", "relative error", r, x);
    check(fi === 1'b0 && fz === 1'b0, "R11", "flags on normal",
          {30'h0, fi, fz}, 32'h0);
  endtask

  task automatic check_pow(input logic [31:0] x, input logic [31:0] exp);
    logic [31:0] r;
    logic fi, fz;
    run_op(x, 0, r, fi, fz);
    check(r === exp && !fi && !fz, "R5", "exact power of two", r, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    repeat (4) @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R12", "in reset",
          {30'h0, in_ready, out_valid}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R12", "after reset",
          {30'h0, in_ready, out_valid}, 32'h2);

    // R6 NaN handling
    check_special(32'h7FC0_0001, 32'h7FC0_0001, 1'b0, 1'b0, "R6");
    check_special(32'h7F80_0001, 32'h7FC0_0001, 1'b1, 1'b0, "R6");
    check_special(32'hFFA0_1234, 32'hFFE0_1234, 1'b1, 1'b0, "R6");
    // R7 negatives
    check_special(32'hBF80_0000, 32'hFFC0_0000, 1'b1, 1'b0, "R7");
    check_special(32'hFF80_0000, 32'hFFC0_0000, 1'b1, 1'b0, "R7");
    check_special(32'h8080_0000, 32'hFFC0_0000, 1'b1, 1'b0, "R7");
    // R8 negative zero / subnormal
    check_special(32'h8000_0000, 32'hFF80_0000, 1'b0, 1'b1, "R8");
    check_special(32'h8000_0001, 32'hFF80_0000, 1'b0, 1'b1, "R8");
    // R9 positive zero / subnormal
    check_special(32'h0000_0000, 32'h7F80_0000, 1'b0, 1'b1, "R9");
    check_special(32'h007F_FFFF, 32'h7F80_0000, 1'b0, 1'b1, "R9");
    // R10 positive infinity
    check_special(32'h7F80_0000, 32'h0000_0000, 1'b0, 1'b0, "R10");

    // R5 exact powers
    check_pow(32'h3F80_0000, 32'h3F80_0000);
    check_pow(32'h3E80_0000, 32'h4000_0000);
    check_pow(32'h4080_0000, 32'h3F00_0000);
    check_pow(32'h0080_0000, 32'h5F00_0000);
    check_pow(32'h7E80_0000, 32'h2000_0000);

    // R4 directed normals: odd exponent, near one, extremes
    check_normal(32'h4000_0000, 0);
    check_normal(32'h4040_0000, 0);
    check_normal(32'h3F80_0001, 0);
    check_normal(32'h3FFF_FFFF, 0);
    check_normal(32'h7F7F_FFFF, 0);
    check_normal(32'h00FF_FFFF, 0);
    // R3 back-pressure
    check_normal(32'h4049_0FDB, 3);
    check_special(32'h7F80_0001, 32'h7FC0_0001, 1'b1, 1'b0, "R6");

    // R4 random positive normals
    for (int k = 0; k < 250; k++) begin
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      x = {1'b0, 8'(1 + (rs[31:8] % 254)), rs[22:0]};
      check_normal(x, (k % 17 == 0) ? 2 : 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule